// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block owns the SDRAM command bus from reset until the memory is ready. It first keeps the bus idle with NOP commands for a power-up delay. It then closes every bank with a precharge-all command and issues a run of auto-refresh commands. Last, it loads the mode register with a word built from parameters. A single down-counter enforces each gap between commands. Every wait count is derived at elaboration from the clock frequency and the timing parameters in nanoseconds or microseconds.

All bus outputs come straight from registers, so each command is steady for a full clock period on both sides of the edge that the memory samples. When the last wait has expired, `init_done` rises and stays high until the next reset. The operational controller takes over the bus from that point. This block only drives NOP after handing over.

Top module: `sdinit_seq`

## Requirements
- R1: Commands are encoded as {cs_n, ras_n, cas_n, we_n}: NOP = 0111, precharge = 0010, auto-refresh = 0001, mode load = 0000. While reset is low, and until the power-up wait has passed, the bus shows NOP, `init_done` is 0 and the address is 0. The power-up wait is PWR = POWERUP_US*CLK_MHZ cycles.
- R2: The first non-NOP command is a precharge-all. It appears on the PWR-th clock edge after reset is released, with address bit 10 set and every other address bit and the bank bits at 0.
- R3: The first auto-refresh follows the precharge by exactly RP cycles. RP = max(2, ceil(T_RP_NS*CLK_MHZ/1000)).
- R4: Exactly N_AREF auto-refresh commands are issued, each one RFC cycles after the previous one. RFC = max(2, ceil(T_RFC_NS*CLK_MHZ/1000)).
- R5: The mode load follows the last refresh by RFC cycles. During the mode load the bank bits are 0 and the address carries the mode word.
- R6: Mode word bits [2:0] give the burst length: 1 gives 000, 2 gives 001, 4 gives 010, 8 gives 011, and full page (BURST_LEN = 0) gives 111.
- R7: Mode word bit 3 is the burst type (0 means sequential, 1 means interleaved). Bits [6:4] hold the CAS latency (2 or 3). Bits [8:7] are 0, which selects standard operation.
- R8: Mode word bit 9 is the write mode. When it is 1, each write moves a single word. When it is 0, writes burst just as reads do.
- R9: Address bits from 10 upward are 0 during the mode load.
- R10: `init_done` rises MRD = max(2, T_MRD_CYC) cycles after the mode load. It then stays high until reset, and the bus shows only NOP from that point.
- R11: Every command lasts exactly one cycle and is followed by at least one NOP cycle.
- R12: Asserting reset in the middle of the sequence returns the bus to NOP and clears `init_done`. Releasing reset restarts the whole sequence with fresh timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock; commands change on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BA_W | Bank select |
| sd_addr | output | ADDR_W | Address pins; carry the A10 flag and the mode word |
| init_done | output | 1 | High once initialization is complete; bus ownership passes on |

## Verification
Two instances are tried. The defaults use a 10000-cycle power-up wait, two refreshes, burst 4, sequential bursts, CAS latency 3 and burst writes. The second configuration uses a short wait, four refreshes, burst 8, interleaved bursts, CAS latency 2 and single-word writes. Between them, the two instances show whether the refresh count, the rounding of each gap and every mode-word field really follow the parameters, rather than being fixed values. The second instance is also reset just after its second refresh. This shows whether the counter, the refresh tally and the done flag restart from scratch, or whether the sequence resumes partway through.

// File: rtl/sdinit_pkg.sv
// Shared command codes, phase type and timing helpers for the SDRAM
// initialization sequencer. Assumes commands are the 4-bit tuple
// {cs_n, ras_n, cas_n, we_n}.
package sdinit_pkg;

    typedef enum logic [3:0] {
        CMD_MRS = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_NOP = 4'b0111
    } sd_cmd_e;

    typedef enum logic [2:0] {
        PH_PRE,
        PH_REF,
        PH_MRS,
        PH_DONE,
        PH_HOLD
    } phase_e;

    // Larger of two values; also keeps every gap at least two cycles.
    function automatic int unsigned max_u(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Nanoseconds to clock cycles, rounded up, never below two.
    function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned mhz);
        return max_u((ns * mhz + 999) / 1000, 2);
    endfunction

endpackage

// File: rtl/sdinit_timer.sv
// Wait counter shared by every gap in the sequence. It loads a value,
// counts down to zero and holds there. Assumes load only when zero.
module sdinit_timer #(
    parameter int unsigned CNT_W   = 14,
    parameter int unsigned RST_VAL = 9999
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);

    logic [CNT_W-1:0] cnt;

    // Counter: reset to the power-up wait, reload on request, else count down.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= CNT_W'(RST_VAL);
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

    // R3: without a reload, a nonzero count falls by exactly one per cycle.
    a_r3_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !zero) |=> (cnt == $past(cnt) - 1'b1));

    // R10: once drained and not reloaded, the counter stays at zero.
    a_r10_zero_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (zero && !load) |=> zero);

endmodule

// File: rtl/sdinit_modeword.sv
// Builds the mode-register word from parameters. Assumes ADDR_W >= 11,
// BURST_LEN in {0 (full page), 1, 2, 4, 8} and CAS_LAT in {2, 3}.
module sdinit_modeword #(
    parameter int unsigned ADDR_W           = 13,
    parameter int unsigned BURST_LEN        = 4,
    parameter bit          BURST_INTERLEAVE = 1'b0,
    parameter int unsigned CAS_LAT          = 3,
    parameter bit          WRITE_SINGLE     = 1'b0
) (
    output logic [ADDR_W-1:0] word
);

    // Burst-length code; full page selects the all-ones code.
    function automatic logic [2:0] bl_code(int unsigned bl);
        case (bl)
            1:       return 3'b000;
            2:       return 3'b001;
            4:       return 3'b010;
            8:       return 3'b011;
            default: return 3'b111;
        endcase
    endfunction

    localparam logic [2:0] BL_BITS = bl_code(BURST_LEN);
    localparam logic [2:0] CL_BITS = 3'(CAS_LAT);

    // Field assembly: every bit not named below stays zero.
    always_comb begin
        word      = '0;
        word[2:0] = BL_BITS;
        word[3]   = BURST_INTERLEAVE;
        word[6:4] = CL_BITS;
        word[8:7] = 2'b00;
        word[9]   = WRITE_SINGLE;
    end

endmodule

// File: rtl/sdinit_seq.sv
// SDRAM power-up initialization sequencer (top). It runs the power-up
// wait, then precharge-all, then N_AREF auto-refreshes, then the mode load,
// and then raises init_done. Assumes a synchronous active-low reset and that
// the operational controller takes the bus once init_done is high. All bus
// outputs are registered so they stay steady around the sampling edge.
module sdinit_seq
    import sdinit_pkg::*;
#(
    parameter int unsigned CLK_MHZ          = 50,
    parameter int unsigned POWERUP_US       = 200,
    parameter int unsigned T_RP_NS          = 45,
    parameter int unsigned T_RFC_NS         = 130,
    parameter int unsigned T_MRD_CYC        = 3,
    parameter int unsigned N_AREF           = 2,
    parameter int unsigned BURST_LEN        = 4,
    parameter bit          BURST_INTERLEAVE = 1'b0,
    parameter int unsigned CAS_LAT          = 3,
    parameter bit          WRITE_SINGLE     = 1'b0,
    parameter int unsigned ADDR_W           = 13,
    parameter int unsigned BA_W             = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [BA_W-1:0]   sd_ba,
    output logic [ADDR_W-1:0] sd_addr,
    output logic              init_done
);

    localparam int unsigned PWR_CYC = max_u(POWERUP_US * CLK_MHZ, 2);
    localparam int unsigned RP_CYC  = ns_to_cyc(T_RP_NS, CLK_MHZ);
    localparam int unsigned RFC_CYC = ns_to_cyc(T_RFC_NS, CLK_MHZ);
    localparam int unsigned MRD_CYC = max_u(T_MRD_CYC, 2);
    localparam int unsigned MAX_CYC = max_u(max_u(PWR_CYC, RP_CYC), max_u(RFC_CYC, MRD_CYC));
    localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);
    localparam int unsigned REF_W   = $clog2(max_u(N_AREF, 2));
    localparam int unsigned A10     = 10;

    phase_e            phase;
    logic [REF_W-1:0]  ref_left;
    sd_cmd_e           cmd_q;
    logic [ADDR_W-1:0] addr_q;
    logic [BA_W-1:0]   ba_q;
    logic              done_q;
    logic              tmr_zero;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic [ADDR_W-1:0] mode_word;

    sdinit_timer #(
        .CNT_W   (CNT_W),
        .RST_VAL (PWR_CYC - 1)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    sdinit_modeword #(
        .ADDR_W           (ADDR_W),
        .BURST_LEN        (BURST_LEN),
        .BURST_INTERLEAVE (BURST_INTERLEAVE),
        .CAS_LAT          (CAS_LAT),
        .WRITE_SINGLE     (WRITE_SINGLE)
    ) u_mode (
        .word (mode_word)
    );

    // Gap selection: the command issued now sets the wait before the next one.
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        if (tmr_zero) begin
            case (phase)
                PH_PRE:  begin tmr_load = 1'b1; tmr_val = CNT_W'(RP_CYC - 1);  end
                PH_REF:  begin tmr_load = 1'b1; tmr_val = CNT_W'(RFC_CYC - 1); end
                PH_MRS:  begin tmr_load = 1'b1; tmr_val = CNT_W'(MRD_CYC - 1); end
                default: begin tmr_load = 1'b0; tmr_val = '0;                  end
            endcase
        end
    end

    // Sequence engine: issue one command per expired wait, NOP otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_PRE;
            ref_left <= '0;
            cmd_q    <= CMD_NOP;
            addr_q   <= '0;
            ba_q     <= '0;
            done_q   <= 1'b0;
        end else begin
            cmd_q  <= CMD_NOP;
            addr_q <= '0;
            ba_q   <= '0;
            if (tmr_zero) begin
                case (phase)
                    PH_PRE: begin
                        cmd_q       <= CMD_PRE;
                        addr_q[A10] <= 1'b1;
                        ref_left    <= REF_W'(N_AREF - 1);
                        phase       <= PH_REF;
                    end
                    PH_REF: begin
                        cmd_q <= CMD_REF;
                        if (ref_left == '0)
                            phase <= PH_MRS;
                        else
                            ref_left <= ref_left - 1'b1;
                    end
                    PH_MRS: begin
                        cmd_q  <= CMD_MRS;
                        addr_q <= mode_word;
                        phase  <= PH_DONE;
                    end
                    PH_DONE: begin
                        done_q <= 1'b1;
                        phase  <= PH_HOLD;
                    end
                    default: phase <= PH_HOLD;
                endcase
            end
        end
    end

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
    assign sd_ba     = ba_q;
    assign sd_addr   = addr_q;
    assign init_done = done_q;

    // R1: while a wait is still running, the next bus cycle is a NOP.
    a_r1_nop_while_waiting: assert property (@(posedge clk) disable iff (!rst_n)
        (!tmr_zero) |=> (cmd_q == CMD_NOP));

    // R2: precharge always targets all banks.
    a_r2_precharge_all: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == CMD_PRE) |-> (addr_q[A10] && ba_q == '0));

    // R9: no stray upper address bits during the mode load.
    a_r9_mrs_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == CMD_MRS) |-> (addr_q[ADDR_W-1:A10] == '0 && ba_q == '0));

    // R11: a command never repeats into the following cycle.
    a_r11_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q != CMD_NOP) |=> (cmd_q == CMD_NOP));

    // R10: done is sticky until reset.
    a_r10_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    // R10: after hand-over only NOP is driven.
    a_r10_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> (cmd_q == CMD_NOP));

endmodule

// File: tb/sim_sdinit_seq.sv
`timescale 1ns/1ps
// Scoreboard bench: push_seq fills a queue of expected commands per
// instance, and a monitor pops and compares them as the bus produces them.
module sim_sdinit_seq;

    localparam logic [3:0] NOP = 4'b0111;
    localparam logic [3:0] PRE = 4'b0010;
    localparam logic [3:0] REF = 4'b0001;
    localparam logic [3:0] MRS = 4'b0000;

    typedef struct {
        int         cyc;
        logic [3:0] cmd;
        logic [12:0] addr;
        string      req;
    } exp_t;

    logic clk = 1'b0;
    logic rst0_n = 1'b0;
    logic rst1_n = 1'b0;
    always #10 clk = ~clk;

    logic        cs0, ras0, cas0, we0, done0, cs1, ras1, cas1, we1, done1;
    logic [1:0]  ba0, ba1;
    logic [12:0] addr0, addr1;

    // u0: defaults. Expected PWR 10000, RP ceil(2.25)=3, RFC ceil(6.5)=7, MRD 3.
    // Mode word: BL4=010, seq, CL3, burst write -> 13'h032.
    sdinit_seq u0 (
        .clk(clk), .rst_n(rst0_n), .sd_cs_n(cs0), .sd_ras_n(ras0),
        .sd_cas_n(cas0), .sd_we_n(we0), .sd_ba(ba0), .sd_addr(addr0),
        .init_done(done0)
    );

    // u1: PWR 10*100=1000, RP ceil(1.5)=2, RFC 6, MRD 2, four refreshes.
    // Mode word: BL8=011, interleaved, CL2, single write -> 13'h22B.
    sdinit_seq #(
        .CLK_MHZ(100), .POWERUP_US(10), .T_RP_NS(15), .T_RFC_NS(60),
        .T_MRD_CYC(2), .N_AREF(4), .BURST_LEN(8), .BURST_INTERLEAVE(1'b1),
        .CAS_LAT(2), .WRITE_SINGLE(1'b1)
    ) u1 (
        .clk(clk), .rst_n(rst1_n), .sd_cs_n(cs1), .sd_ras_n(ras1),
        .sd_cas_n(cas1), .sd_we_n(we1), .sd_ba(ba1), .sd_addr(addr1),
        .init_done(done1)
    );

    int   checks = 0;
    int   errors = 0;
    bit   finished = 1'b0;
    exp_t q0[$];
    exp_t q1[$];
    int   exp_done [2];
    bit   prev_busy [2];
    bit   seen_done [2];
    int   c0 = 0;
    int   c1 = 0;

    // Cycle counters: edges since reset release, matching the design's view.
    always @(posedge clk) begin
        c0 <= rst0_n ? c0 + 1 : 0;
        c1 <= rst1_n ? c1 + 1 : 0;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Driver: expected command stream from the requirement formulas.
    task automatic push_seq(input int w, input int pwr, input int rp, input int rfc,
                            input int mrd, input int nref, input logic [12:0] mw);
        exp_t e;
        int t = pwr;
        e.cyc = t; e.cmd = PRE; e.addr = 13'h400; e.req = "R2";
        if (w == 0) q0.push_back(e); else q1.push_back(e);
        t += rp;
        for (int i = 0; i < nref; i++) begin
            e.cyc = t; e.cmd = REF; e.addr = 13'h000; e.req = (i == 0) ? "R3" : "R4";
            if (w == 0) q0.push_back(e); else q1.push_back(e);
            t += rfc;
        end
        e.cyc = t; e.cmd = MRS; e.addr = mw; e.req = "R5";
        if (w == 0) q0.push_back(e); else q1.push_back(e);
        exp_done[w] = t + mrd;
    endtask

    // Monitor step: compare one bus cycle against the scoreboard.
    task automatic mon(input int w, input int c, input logic [3:0] cmd,
                       input logic [12:0] addr, input logic [1:0] ba, input logic done);
        exp_t e;
        if (prev_busy[w])
            check(cmd == NOP, "R11", "cycle after command", 32'(cmd), 32'(NOP));
        prev_busy[w] = (cmd != NOP);
        if (cmd != NOP) begin
            if ((w == 0 && q0.size() == 0) || (w == 1 && q1.size() == 0)) begin
                check(1'b0, "R1", "unexpected command", 32'(cmd), 32'(NOP));
            end else begin
                e = (w == 0) ? q0.pop_front() : q1.pop_front();
                check(c == e.cyc, e.req, "issue cycle", 32'(c), 32'(e.cyc));
                check(cmd == e.cmd, e.req, "command code", 32'(cmd), 32'(e.cmd));
                check(ba == 2'b00, e.req, "bank bits", 32'(ba), 32'h0);
                if (e.cmd == PRE)
                    check(addr == 13'h400, "R2", "precharge-all address", 32'(addr), 32'h400);
                if (e.cmd == MRS) begin
                    check(addr[2:0] == e.addr[2:0], "R6", "burst length field",
                          32'(addr[2:0]), 32'(e.addr[2:0]));
                    check(addr[8:3] == e.addr[8:3], "R7", "type/latency/mode field",
                          32'(addr[8:3]), 32'(e.addr[8:3]));
                    check(addr[9] == e.addr[9], "R8", "write mode bit",
                          32'(addr[9]), 32'(e.addr[9]));
                    check(addr[12:10] == 3'b000, "R9", "upper address bits",
                          32'(addr[12:10]), 32'h0);
                end
            end
        end
        if (done && !seen_done[w]) begin
            seen_done[w] = 1'b1;
            check(c == exp_done[w], "R10", "done rise cycle", 32'(c), 32'(exp_done[w]));
        end else if (!done && seen_done[w]) begin
            check(1'b0, "R10", "done dropped", 32'(done), 32'h1);
        end
    endtask

    // Monitor process: sample away from the active edge.
    always @(negedge clk) begin
        if (!finished) begin
            if (rst0_n) mon(0, c0, {cs0, ras0, cas0, we0}, addr0, ba0, done0);
            else begin prev_busy[0] = 1'b0; seen_done[0] = 1'b0; end
            if (rst1_n) mon(1, c1, {cs1, ras1, cas1, we1}, addr1, ba1, done1);
            else begin prev_busy[1] = 1'b0; seen_done[1] = 1'b0; end
        end
    end

    task automatic chk_reset(input int w, input string req);
        if (w == 0) begin
            check({cs0, ras0, cas0, we0} == NOP, req, "u0 reset command", 32'({cs0, ras0, cas0, we0}), 32'(NOP));
            check(done0 == 1'b0 && addr0 == 13'h0, req, "u0 reset done/addr", 32'({done0, addr0}), 32'h0);
        end else begin
            check({cs1, ras1, cas1, we1} == NOP, req, "u1 reset command", 32'({cs1, ras1, cas1, we1}), 32'(NOP));
            check(done1 == 1'b0 && addr1 == 13'h0, req, "u1 reset done/addr", 32'({done1, addr1}), 32'h0);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        push_seq(0, 10000, 3, 7, 3, 2, 13'h032);
        push_seq(1, 1000, 2, 6, 2, 4, 13'h22B);
        repeat (4) @(posedge clk);
        #3;
        chk_reset(0, "R1");
        chk_reset(1, "R1");
        rst0_n = 1'b1;
        rst1_n = 1'b1;

        // R12: reset u1 right after its second refresh (cycle 1008).
        wait (c1 == 1010);
        @(posedge clk);
        #3;
        rst1_n = 1'b0;
        q1.delete();
        repeat (3) @(posedge clk);
        #3;
        chk_reset(1, "R12");
        push_seq(1, 1000, 2, 6, 2, 4, 13'h22B);
        rst1_n = 1'b1;

        wait (done0 && done1);
        repeat (50) @(posedge clk);
        #3;
        check(done0 && done1, "R10", "done still high", 32'({done0, done1}), 32'h3);
        check(q0.size() == 0, "R4", "u0 commands outstanding", 32'(q0.size()), 32'h0);
        check(q1.size() == 0, "R12", "u1 commands outstanding", 32'(q1.size()), 32'h0);
        finish_run();
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (40000) @(posedge clk);
        check(1'b0, "R10", "watchdog expired", 32'h0, 32'h1);
        finish_run();
    end

endmodule